// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is a down-counting timer private to one processor core. It divides the input clock in two stages. A tick counter reloads from a tick reload value and emits one tick each time it passes zero. An event counter counts those ticks and, when it passes zero, flags an expiry and can raise an interrupt. In repeating mode the event counter reloads and the timer keeps firing at a fixed period. In single-shot mode it fires once and then halts.

Software drives the timer through a small word-addressed register port. Writes take effect on the rising clock edge. Reads are combinational. A new event count is accepted only when the write carries an update flag. Every write to the tick value, the event value or the control word is acknowledged through a sticky write-acknowledge bit. Both the interrupt flag and the acknowledge bits are cleared by writing 1. A typical setup programs a tick reload of 1, which ticks at half the clock rate. It then loads an event count with the update flag, enables the interrupt, and sets both run bits.

Top module: `local_tick_timer`

## Requirements
- R1: After reset every register (control, tick reload, event reload, interrupt enable, interrupt flag, write-acknowledge) and both counters read zero, and `irq` is low.
- R2: With tick reload N (address 1) and both counters running, the event counter (readable at address 6) decrements once every N+1 clock cycles.
- R3: When a control write (address 0) sets run bits 0 and 1 while the timer is not already running, the interrupt flag (address 4, bit 0) becomes 1 exactly (N+1)(M+1) rising edges after the write edge. Here M is the event reload value.
- R4: With repeat bit 2 of the control word set, the event counter reloads from M on each expiry, and the flag rises again every (N+1)(M+1) cycles.
- R5: With bit 2 clear, the timer halts after one expiry: the flag does not rise again and the event counter stays at 0.
- R6: A write to the event reload register (address 2) loads bits 30:0 only when bit 31 is 1. A write with bit 31 at 0 leaves the stored value unchanged.
- R7: `irq` equals the interrupt flag ANDed with bit 0 of the interrupt enable register (address 3). The flag is set regardless of the enable.
- R8: Writing 1 to bit 0 of address 4 clears the interrupt flag. Writing 0 leaves it set.
- R9: The write-acknowledge register (address 5) sets bit 0 on a write to address 1, bit 1 on a write to address 2 and bit 3 on a write to address 0. Writes to other addresses set nothing. Each bit is cleared by writing 1 to it.
- R10: Clearing either run bit freezes both counters (tick counter at address 7). Setting both again reloads the tick counter with N and the event counter with M.
- R11: Event reload values up to 0x7FFFFFFF and tick reload values up to 0xFFFFFFFF are stored and read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 3 | Word address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest situation to reach is the freeze-and-resume case: a run bit must be cleared at a known edge in mid-count, with the counter's frozen value predictable. The stimulus starts the timer with a slow tick and a large event count, waits a fixed number of edges, and clears only the event run bit. It then computes the expected frozen count from the edges elapsed and reads it twice across an idle gap. After that it restarts the timer to confirm that both reload values return. The repeating-mode period is measured across an interrupt clear, and the clear itself costs one edge, so the next expiry is checked one edge before and exactly on its predicted cycle.

// File: rtl/ltt_pkg.sv
package ltt_pkg;

  localparam int ADDR_W = 3;
  localparam int WS_W   = 4;

  // control word bit positions
  localparam int CTL_TICK_RUN = 0;
  localparam int CTL_EVT_RUN  = 1;
  localparam int CTL_REPEAT   = 2;

  // write-acknowledge bit positions
  localparam int WS_TBUF = 0;
  localparam int WS_EBUF = 1;
  localparam int WS_CTRL = 3;
  localparam logic [WS_W-1:0] WS_LIVE = WS_W'((1 << WS_TBUF) | (1 << WS_EBUF) | (1 << WS_CTRL));

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_TBUF  = 3'd1,
    REG_EBUF  = 3'd2,
    REG_IEN   = 3'd3,
    REG_IFLAG = 3'd4,
    REG_WACK  = 3'd5,
    REG_ECNT  = 3'd6,
    REG_TCNT  = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic reload;    // load both counters from their reload values
    logic count;     // advance the counters this cycle
    logic repeatOn;  // reload event counter on expiry
  } cntStrobe_t;

endpackage

// File: rtl/ltt_datapath.sv
module ltt_datapath
  import ltt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int EVT_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strobes,
  input  logic [TICK_W-1:0] tickBuf,
  input  logic [EVT_W-1:0]  evtBuf,
  output logic [TICK_W-1:0] tickCnt,
  output logic [EVT_W-1:0]  evtCnt,
  output logic              expire
);

  logic tickZero;
  logic evtZero;
  logic tickFire;

  assign tickZero = (tickCnt == '0);
  assign evtZero  = (evtCnt == '0);
  assign tickFire = strobes.count & tickZero;
  assign expire   = tickFire & evtZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobes.reload) begin
      tickCnt <= tickBuf;
    end else if (strobes.count) begin
      if (tickZero) tickCnt <= tickBuf;
      else          tickCnt <= tickCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCnt <= '0;
    end else if (strobes.reload) begin
      evtCnt <= evtBuf;
    end else if (tickFire) begin
      if (!evtZero)              evtCnt <= evtCnt - 1'b1;
      else if (strobes.repeatOn) evtCnt <= evtBuf;
    end
  end

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.count && !strobes.reload) |=> ($stable(tickCnt) && $stable(evtCnt)));

  // R10
  restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> (tickCnt == $past(tickBuf) && evtCnt == $past(evtBuf)));

  // R4
  repeat_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strobes.repeatOn) |=> (evtCnt == $past(evtBuf)));

endmodule

// File: rtl/ltt_ctrl.sv
module ltt_ctrl
  import ltt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TICK_W = 32,
  parameter int EVT_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              expire,
  input  logic [TICK_W-1:0] tickCnt,
  input  logic [EVT_W-1:0]  evtCnt,
  output cntStrobe_t        strobes,
  output logic [TICK_W-1:0] tickBuf,
  output logic [EVT_W-1:0]  evtBuf,
  output logic              irq
);

  localparam int UPD_BIT = DATA_W - 1;

  logic ctlTickRun, ctlEvtRun, ctlRepeat;
  logic irqEn, intFlag, oneShotDone;
  logic [WS_W-1:0] wackBits;
  logic [WS_W-1:0] wackSet, wackClr;

  logic wrCtrl, wrTbuf, wrEbuf, wrIen, wrFlag, wrWack;
  logic running, startReq;

  assign wrCtrl = wrEn && (regAddr_e'(addr) == REG_CTRL);
  assign wrTbuf = wrEn && (regAddr_e'(addr) == REG_TBUF);
  assign wrEbuf = wrEn && (regAddr_e'(addr) == REG_EBUF);
  assign wrIen  = wrEn && (regAddr_e'(addr) == REG_IEN);
  assign wrFlag = wrEn && (regAddr_e'(addr) == REG_IFLAG);
  assign wrWack = wrEn && (regAddr_e'(addr) == REG_WACK);

  assign running  = ctlTickRun & ctlEvtRun;
  assign startReq = wrCtrl & wrData[CTL_TICK_RUN] & wrData[CTL_EVT_RUN] & ~running;

  assign strobes.reload   = startReq;
  assign strobes.count    = running & ~oneShotDone;
  assign strobes.repeatOn = ctlRepeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlTickRun <= 1'b0;
      ctlEvtRun  <= 1'b0;
      ctlRepeat  <= 1'b0;
    end else if (wrCtrl) begin
      ctlTickRun <= wrData[CTL_TICK_RUN];
      ctlEvtRun  <= wrData[CTL_EVT_RUN];
      ctlRepeat  <= wrData[CTL_REPEAT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickBuf <= '0;
      evtBuf  <= '0;
      irqEn   <= 1'b0;
    end else begin
      if (wrTbuf) tickBuf <= wrData[TICK_W-1:0];
      if (wrEbuf && wrData[UPD_BIT]) evtBuf <= wrData[EVT_W-1:0];
      if (wrIen) irqEn <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag     <= 1'b0;
      oneShotDone <= 1'b0;
    end else begin
      if (expire)                    intFlag <= 1'b1;
      else if (wrFlag && wrData[0])  intFlag <= 1'b0;
      if (startReq)                  oneShotDone <= 1'b0;
      else if (expire && !ctlRepeat) oneShotDone <= 1'b1;
    end
  end

  always_comb begin
    wackSet          = '0;
    wackSet[WS_TBUF] = wrTbuf;
    wackSet[WS_EBUF] = wrEbuf;
    wackSet[WS_CTRL] = wrCtrl;
    wackClr          = wrWack ? wrData[WS_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wackBits <= '0;
    else       wackBits <= (wackBits | wackSet) & ~wackClr & WS_LIVE;
  end

  assign irq = intFlag & irqEn;

  always_comb begin
    rdData = '0;
    case (regAddr_e'(addr))
      REG_CTRL:  rdData[2:0]        = {ctlRepeat, ctlEvtRun, ctlTickRun};
      REG_TBUF:  rdData[TICK_W-1:0] = tickBuf;
      REG_EBUF:  rdData[EVT_W-1:0]  = evtBuf;
      REG_IEN:   rdData[0]          = irqEn;
      REG_IFLAG: rdData[0]          = intFlag;
      REG_WACK:  rdData[WS_W-1:0]   = wackBits;
      REG_ECNT:  rdData[EVT_W-1:0]  = evtCnt;
      REG_TCNT:  rdData[TICK_W-1:0] = tickCnt;
      default:   rdData             = '0;
    endcase
  end

  // R6
  evt_buf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEbuf && !wrData[UPD_BIT]) |=> $stable(evtBuf));

  // R9
  ctrl_wack_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> wackBits[WS_CTRL]);

  // R3
  expire_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> intFlag);

  // R5
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctlRepeat) |=> !strobes.count);

endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
  import ltt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int EVT_W = DATA_W - 1;

  cntStrobe_t        strobes;
  logic [TICK_W-1:0] tickBuf, tickCnt;
  logic [EVT_W-1:0]  evtBuf, evtCnt;
  logic              expire;

  ltt_ctrl #(.DATA_W(DATA_W), .TICK_W(TICK_W), .EVT_W(EVT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .expire(expire), .tickCnt(tickCnt), .evtCnt(evtCnt),
    .strobes(strobes), .tickBuf(tickBuf), .evtBuf(evtBuf), .irq(irq)
  );

  ltt_datapath #(.TICK_W(TICK_W), .EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tickBuf(tickBuf),
    .evtBuf(evtBuf), .tickCnt(tickCnt), .evtCnt(evtCnt), .expire(expire)
  );

endmodule

// File: tb/local_tick_timer_test.sv
`timescale 1ns/1ps
module local_tick_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  local_tick_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic testBuffers();
    logic [31:0] v;
    regWrite(3'd2, 32'h0000_0005);
    regRead(3'd2, v); check("R6 no-flag write ignored", v, 32'h0);
    regWrite(3'd2, 32'hFFFF_FFFF);
    regRead(3'd2, v); check("R11 max event value", v, 32'h7FFF_FFFF);
    regWrite(3'd2, 32'h0000_0009);
    regRead(3'd2, v); check("R6 value kept", v, 32'h7FFF_FFFF);
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, v); check("R11 max tick value", v, 32'hFFFF_FFFF);
  endtask

  task automatic testWriteAck();
    logic [31:0] v;
    regWrite(3'd5, 32'hF);
    regRead(3'd5, v); check("R9 cleared", v, 32'h0);
    regWrite(3'd1, 32'd1);
    regRead(3'd5, v); check("R9 tick write bit0", v, 32'h1);
    regWrite(3'd3, 32'd0);
    regRead(3'd5, v); check("R9 enable write sets nothing", v, 32'h1);
    regWrite(3'd0, 32'd0);
    regRead(3'd5, v); check("R9 control write bit3", v, 32'h9);
    regWrite(3'd2, 32'h8000_0003);
    regRead(3'd5, v); check("R9 event write bit1", v, 32'hB);
    regWrite(3'd5, 32'h1);
    regRead(3'd5, v); check("R9 clear bit0 only", v, 32'hA);
    regWrite(3'd5, 32'hA);
    regRead(3'd5, v); check("R9 clear rest", v, 32'h0);
  endtask

  // N=1, M=3 single shot, interrupt disabled
  task automatic testOneShot();
    logic [31:0] v;
    regWrite(3'd3, 32'd0);
    regWrite(3'd1, 32'd1);
    regWrite(3'd2, 32'h8000_0003);
    regWrite(3'd0, 32'h3);
    idle(7);
    regRead(3'd4, v); check("R3 flag not yet set", v, 32'h0);
    idle(1);
    regRead(3'd4, v); check("R3 flag at (N+1)(M+1)", v, 32'h1);
    check("R7 irq masked while disabled", {31'b0, irq}, 32'h0);
    regWrite(3'd4, 32'h0);
    regRead(3'd4, v); check("R8 writing 0 keeps flag", v, 32'h1);
    regWrite(3'd4, 32'h1);
    regRead(3'd4, v); check("R8 writing 1 clears flag", v, 32'h0);
    idle(30);
    regRead(3'd4, v); check("R5 no second expiry", v, 32'h0);
    regRead(3'd6, v); check("R5 event counter rests at 0", v, 32'h0);
    regWrite(3'd0, 32'h0);
  endtask

  task automatic testRepeat();
    logic [31:0] v;
    regWrite(3'd3, 32'd1);
    regWrite(3'd1, 32'd1);
    regWrite(3'd2, 32'h8000_0003);
    regWrite(3'd0, 32'h7);
    idle(7);
    check("R7 irq low before expiry", {31'b0, irq}, 32'h0);
    idle(1);
    check("R7 irq high with enable", {31'b0, irq}, 32'h1);
    regWrite(3'd4, 32'h1);
    check("R8 irq low after clear", {31'b0, irq}, 32'h0);
    idle(6);
    check("R4 no early second expiry", {31'b0, irq}, 32'h0);
    idle(1);
    check("R4 second expiry on period", {31'b0, irq}, 32'h1);
    regWrite(3'd0, 32'h0);
    regWrite(3'd4, 32'h1);
    regRead(3'd4, v); check("R8 flag cleared after stop", v, 32'h0);
  endtask

  // N=4, M=2: period 15
  task automatic testTickDivide();
    regWrite(3'd1, 32'd4);
    regWrite(3'd2, 32'h8000_0002);
    regWrite(3'd0, 32'h7);
    idle(14);
    check("R2 no expiry at 14 cycles", {31'b0, irq}, 32'h0);
    idle(1);
    check("R2 expiry at 15 cycles", {31'b0, irq}, 32'h1);
    regWrite(3'd0, 32'h0);
    regWrite(3'd4, 32'h1);
  endtask

  task automatic testHold();
    logic [31:0] a, b;
    regWrite(3'd1, 32'd1);
    regWrite(3'd2, 32'h8000_0064);
    regWrite(3'd0, 32'h7);
    idle(20);
    regWrite(3'd0, 32'h5);
    regRead(3'd6, a); check("R2 count after 21 edges", a, 32'd90);
    idle(10);
    regRead(3'd6, b); check("R10 event counter frozen", b, a);
    regWrite(3'd0, 32'h7);
    regRead(3'd6, a); check("R10 event counter reloaded", a, 32'd100);
    regRead(3'd7, a); check("R10 tick counter reloaded", a, 32'd1);
    regWrite(3'd0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testBuffers();
    testWriteAck();
    testOneShot();
    testRepeat();
    testTickDivide();
    testHold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule